// File: doc/BRIEF.md
# E1 CAS Signaling Buffer Engine

This block handles channel-associated signaling for one E1 port. On the receive side it takes the signaling slot (time slot 16) out of an already aligned serial stream. One byte is captured per frame. A full multiframe of sixteen bytes is presented to the host as one set. On the transmit side the host fills sixteen bytes. At every multiframe start these bytes are frozen into a shadow copy, and the shadow copy is shifted into time slot 16 of the outgoing stream, most significant bit first.

Alignment is not searched for here. The upstream framer supplies the bit position within the frame and the frame number within the multiframe for each direction. The multiframe boundary is the cycle in which the position is bit 0 of frame 0. The host uses a byte-wide register port. It reads and writes the sixteen signaling bytes, a control byte and a status byte. Both status flags are also brought out as pins.

Host map: addresses 0..15 hold signaling bytes 1..16; byte n+1 belongs to frame n. Address 16 is control: bit 0 enables insertion, bit 1 makes signaling reads return the transmit buffer. Address 17 is status: bit 0 means new receive signaling, bit 1 means a transmit multiframe started. Read data is registered and valid one cycle after the address. Any other address reads 0.

Receive FSM states: RX_HUNT, RX_FILL and RX_READY. The transitions are:
- HUNT_TO_FILL: HUNT moves to FILL at a boundary.
- FILL_TO_READY: FILL moves to READY after the signaling slot of frame 15 is captured.
- READY_TO_FILL: READY moves to FILL at a boundary and transfers the snapshot.
- FILL_RESTART: a boundary seen in FILL stays in FILL and transfers nothing.

Transmit FSM states: TX_IDLE and TX_RUN. TX_IDLE moves to TX_RUN at the first boundary (IDLE_TO_RUN). TX_RUN then holds.

Top module: `cas_sig_engine`

## Requirements
- R1: After reset, every host read returns 0 (signaling bytes, control, status), both flag pins are 0 and `tx_out` is 0.
- R2: The 8 bits at frame positions 128..135 of frame n are captured first bit as MSB. They become readable at address n after the multiframe boundary that follows a complete multiframe.
- R3: The receive bytes visible to the host change only at a multiframe boundary. New slot data arriving mid-multiframe does not alter them.
- R4: The first boundary after reset only starts collection. A partial multiframe is never transferred, and the receive status bit stays 0.
- R5: Status bit 0 (`rx_new_flag`) is set when a receive snapshot is transferred and stays set until it is cleared.
- R6: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. A set in the same cycle wins over the clear.
- R7: Status bit 1 (`tx_mf_flag`) is set at every transmit multiframe boundary, including again after it was cleared.
- R8: With control bit 1 set, reads of addresses 0..15 return the transmit buffer. With it clear, they return the receive bytes.
- R9: With control bit 0 clear, or before the first transmit boundary, `tx_out` equals `tx_in` delayed by one clock.
- R10: With control bit 0 set, bit k (0..7) of the slot at positions 128..135 of frame n carries bit 7-k of transmit byte n+1, as frozen at the start of that multiframe. Other positions pass `tx_in`. The latency is one clock. Byte 1 goes out in frame 0, so its upper nibble (the alignment zeros) leads.
- R11: A host write landing on the transmit boundary cycle does not enter the snapshot taken in that cycle. It is transmitted from the following multiframe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit | input | 1 | Receive serial data |
| rx_bit_pos | input | 8 | Receive bit position in frame (0..255) |
| rx_frame | input | 4 | Receive frame number in multiframe |
| tx_in | input | 1 | Outgoing stream before insertion |
| tx_bit_pos | input | 8 | Transmit bit position in frame |
| tx_frame | input | 4 | Transmit frame number in multiframe |
| tx_out | output | 1 | Outgoing stream after insertion |
| host_addr | input | 5 | Register address |
| host_we | input | 1 | Write strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| rx_new_flag | output | 1 | Status bit 0 |
| tx_mf_flag | output | 1 | Status bit 1 |

## Verification
Three receive patterns are used:
- an arithmetic byte sequence, where every frame's byte differs, so a misplaced frame index or reversed bit order is caught;
- a second sequence that arrives while the first must still be held, which separates boundary-only update from continuous update;
- alternating 0x00/0xFF frames, which expose stuck or shifted bits.

On transmit, every output bit is compared across four spans: the pass-through span, a span with insertion enabled but a zero snapshot, a span with loaded bytes, and a span with a write landing on the boundary. The boundary-write span tells a deferred write from one taken into the snapshot immediately.

// File: rtl/cas_sig_pkg.sv
package cas_sig_pkg;

    typedef enum logic [1:0] {
        RX_HUNT  = 2'd0,
        RX_FILL  = 2'd1,
        RX_READY = 2'd2
    } rx_state_e;

    typedef enum logic [0:0] {
        TX_IDLE = 1'b0,
        TX_RUN  = 1'b1
    } tx_state_e;

endpackage

// File: rtl/cas_rx_gather.sv
module cas_rx_gather
    import cas_sig_pkg::*;
#(
    parameter int FRAME_BITS = 256,
    parameter int MF_FRAMES  = 16,
    parameter int SIG_SLOT   = 16,
    parameter int SLOT_BITS  = 8,
    localparam int POS_W     = $clog2(FRAME_BITS),
    localparam int FRM_W     = $clog2(MF_FRAMES)
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  bit_i,
    input  logic [POS_W-1:0]                      pos_i,
    input  logic [FRM_W-1:0]                      frame_i,
    output logic                                  xfer_o,
    output logic [MF_FRAMES-1:0][SLOT_BITS-1:0]   regs_o
);

    localparam int SLOT_FIRST = SIG_SLOT * SLOT_BITS;
    localparam int SLOT_LAST  = SLOT_FIRST + SLOT_BITS - 1;

    rx_state_e state_q, state_d;
    logic      do_xfer;
    logic      in_slot, slot_end, mf_start, last_frame;
    logic [SLOT_BITS-1:0]                 shreg_q;
    logic [SLOT_BITS-1:0]                 next_byte;
    logic [MF_FRAMES-1:0][SLOT_BITS-1:0]  stage_q;

    assign in_slot    = (pos_i >= POS_W'(SLOT_FIRST)) && (pos_i <= POS_W'(SLOT_LAST));
    assign slot_end   = (pos_i == POS_W'(SLOT_LAST));
    assign mf_start   = (pos_i == '0) && (frame_i == '0);
    assign last_frame = (frame_i == FRM_W'(MF_FRAMES - 1));
    assign next_byte  = {shreg_q[SLOT_BITS-2:0], bit_i};

    // next-state logic
    always_comb begin
        state_d = state_q;
        do_xfer = 1'b0;
        unique case (state_q)
            RX_HUNT:  if (mf_start) state_d = RX_FILL;
            RX_FILL:  if (slot_end && last_frame) state_d = RX_READY;
            RX_READY: if (mf_start) begin
                          state_d = RX_FILL;
                          do_xfer = 1'b1;
                      end
            default:  state_d = RX_HUNT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_HUNT;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            stage_q <= '0;
            regs_o  <= '0;
            xfer_o  <= 1'b0;
        end else begin
            xfer_o <= do_xfer;
            if (in_slot) shreg_q <= next_byte;
            if (slot_end) stage_q[frame_i] <= next_byte;
            if (do_xfer) regs_o <= stage_q;
        end
    end

    AST_RX_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_o |-> $stable(regs_o)); // R3

    AST_RX_XFER_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_o |-> ($past(pos_i) == '0) && ($past(frame_i) == '0)); // R2

endmodule

// File: rtl/cas_tx_insert.sv
module cas_tx_insert
    import cas_sig_pkg::*;
#(
    parameter int FRAME_BITS = 256,
    parameter int MF_FRAMES  = 16,
    parameter int SIG_SLOT   = 16,
    parameter int SLOT_BITS  = 8,
    localparam int POS_W     = $clog2(FRAME_BITS),
    localparam int FRM_W     = $clog2(MF_FRAMES)
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  in_i,
    input  logic [POS_W-1:0]                      pos_i,
    input  logic [FRM_W-1:0]                      frame_i,
    input  logic                                  ins_en_i,
    input  logic [MF_FRAMES-1:0][SLOT_BITS-1:0]   buf_i,
    output logic                                  mf_o,
    output logic                                  out_o
);

    localparam int SLOT_FIRST = SIG_SLOT * SLOT_BITS;
    localparam int SLOT_LAST  = SLOT_FIRST + SLOT_BITS - 1;
    localparam int OFF_W      = $clog2(SLOT_BITS);

    tx_state_e state_q, state_d;
    logic      in_slot, mf_start, insert_now;
    logic [OFF_W-1:0]                     bit_sel;
    logic [MF_FRAMES-1:0][SLOT_BITS-1:0]  shadow_q;
    logic [SLOT_BITS-1:0]                 cur_byte;

    assign in_slot    = (pos_i >= POS_W'(SLOT_FIRST)) && (pos_i <= POS_W'(SLOT_LAST));
    assign mf_start   = (pos_i == '0) && (frame_i == '0);
    assign bit_sel    = OFF_W'(SLOT_LAST - int'(pos_i));
    assign cur_byte   = shadow_q[frame_i];
    assign insert_now = (state_q == TX_RUN) && ins_en_i && in_slot;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: if (mf_start) state_d = TX_RUN;
            TX_RUN:  state_d = TX_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= '0;
            mf_o     <= 1'b0;
            out_o    <= 1'b0;
        end else begin
            mf_o  <= mf_start;
            out_o <= insert_now ? cur_byte[bit_sel] : in_i;
            if (mf_start) shadow_q <= buf_i;
        end
    end

    AST_TX_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(ins_en_i)) |-> (out_o == $past(in_i))); // R9

    AST_TX_MF_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        mf_o |-> ($past(pos_i) == '0) && ($past(frame_i) == '0)); // R7

endmodule

// File: rtl/cas_host_regs.sv
module cas_host_regs #(
    parameter int MF_FRAMES = 16,
    parameter int SLOT_BITS = 8,
    localparam int FRM_W    = $clog2(MF_FRAMES),
    localparam int AW       = FRM_W + 1
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [AW-1:0]                         addr_i,
    input  logic                                  we_i,
    input  logic [SLOT_BITS-1:0]                  wdata_i,
    output logic [SLOT_BITS-1:0]                  rdata_o,
    input  logic [MF_FRAMES-1:0][SLOT_BITS-1:0]   rx_regs_i,
    input  logic                                  rx_xfer_i,
    input  logic                                  tx_mf_i,
    output logic [MF_FRAMES-1:0][SLOT_BITS-1:0]   txbuf_o,
    output logic                                  ins_en_o,
    output logic                                  stat_rx_o,
    output logic                                  stat_tx_o
);

    localparam int CTRL_ADDR = MF_FRAMES;
    localparam int STAT_ADDR = MF_FRAMES + 1;

    logic                 rb_q;
    logic                 sig_sel, ctrl_wr, stat_wr;
    logic [FRM_W-1:0]     idx;
    logic [SLOT_BITS-1:0] rd_mux;

    assign sig_sel = (addr_i < AW'(MF_FRAMES));
    assign idx     = addr_i[FRM_W-1:0];
    assign ctrl_wr = we_i && (addr_i == AW'(CTRL_ADDR));
    assign stat_wr = we_i && (addr_i == AW'(STAT_ADDR));

    always_comb begin
        rd_mux = '0;
        if (sig_sel) begin
            rd_mux = rb_q ? txbuf_o[idx] : rx_regs_i[idx];
        end else if (addr_i == AW'(CTRL_ADDR)) begin
            rd_mux[0] = ins_en_o;
            rd_mux[1] = rb_q;
        end else if (addr_i == AW'(STAT_ADDR)) begin
            rd_mux[0] = stat_rx_o;
            rd_mux[1] = stat_tx_o;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txbuf_o   <= '0;
            ins_en_o  <= 1'b0;
            rb_q      <= 1'b0;
            stat_rx_o <= 1'b0;
            stat_tx_o <= 1'b0;
            rdata_o   <= '0;
        end else begin
            rdata_o <= rd_mux;
            if (we_i && sig_sel) txbuf_o[idx] <= wdata_i;
            if (ctrl_wr) begin
                ins_en_o <= wdata_i[0];
                rb_q     <= wdata_i[1];
            end
            stat_rx_o <= rx_xfer_i | (stat_rx_o & ~(stat_wr & wdata_i[0]));
            stat_tx_o <= tx_mf_i   | (stat_tx_o & ~(stat_wr & wdata_i[1]));
        end
    end

    AST_RX_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(stat_rx_o) && !$past(stat_wr && wdata_i[0])) |-> stat_rx_o); // R5

    AST_STAT_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(stat_wr && wdata_i[1] && !tx_mf_i)) |-> !stat_tx_o); // R6

endmodule

// File: rtl/cas_sig_engine.sv
module cas_sig_engine #(
    parameter int FRAME_BITS = 256,
    parameter int MF_FRAMES  = 16,
    parameter int SIG_SLOT   = 16,
    parameter int SLOT_BITS  = 8,
    localparam int POS_W     = $clog2(FRAME_BITS),
    localparam int FRM_W     = $clog2(MF_FRAMES),
    localparam int AW        = FRM_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_bit,
    input  logic [POS_W-1:0]     rx_bit_pos,
    input  logic [FRM_W-1:0]     rx_frame,
    input  logic                 tx_in,
    input  logic [POS_W-1:0]     tx_bit_pos,
    input  logic [FRM_W-1:0]     tx_frame,
    output logic                 tx_out,
    input  logic [AW-1:0]        host_addr,
    input  logic                 host_we,
    input  logic [SLOT_BITS-1:0] host_wdata,
    output logic [SLOT_BITS-1:0] host_rdata,
    output logic                 rx_new_flag,
    output logic                 tx_mf_flag
);

    logic [MF_FRAMES-1:0][SLOT_BITS-1:0] rx_regs;
    logic [MF_FRAMES-1:0][SLOT_BITS-1:0] tx_buf;
    logic rx_xfer, tx_mf, ins_en;

    cas_rx_gather #(
        .FRAME_BITS(FRAME_BITS), .MF_FRAMES(MF_FRAMES),
        .SIG_SLOT(SIG_SLOT), .SLOT_BITS(SLOT_BITS)
    ) u_rx (
        .clk(clk), .rst_n(rst_n), .bit_i(rx_bit), .pos_i(rx_bit_pos),
        .frame_i(rx_frame), .xfer_o(rx_xfer), .regs_o(rx_regs)
    );

    cas_tx_insert #(
        .FRAME_BITS(FRAME_BITS), .MF_FRAMES(MF_FRAMES),
        .SIG_SLOT(SIG_SLOT), .SLOT_BITS(SLOT_BITS)
    ) u_tx (
        .clk(clk), .rst_n(rst_n), .in_i(tx_in), .pos_i(tx_bit_pos),
        .frame_i(tx_frame), .ins_en_i(ins_en), .buf_i(tx_buf),
        .mf_o(tx_mf), .out_o(tx_out)
    );

    cas_host_regs #(
        .MF_FRAMES(MF_FRAMES), .SLOT_BITS(SLOT_BITS)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .addr_i(host_addr), .we_i(host_we),
        .wdata_i(host_wdata), .rdata_o(host_rdata), .rx_regs_i(rx_regs),
        .rx_xfer_i(rx_xfer), .tx_mf_i(tx_mf), .txbuf_o(tx_buf),
        .ins_en_o(ins_en), .stat_rx_o(rx_new_flag), .stat_tx_o(tx_mf_flag)
    );

endmodule

// File: tb/cas_sig_engine_bench.sv
module cas_sig_engine_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_bit = 1'b0, tx_in = 1'b0, host_we = 1'b0;
    logic [7:0] rx_bit_pos = 8'd1, tx_bit_pos = 8'd1;
    logic [3:0] rx_frame = 4'd0, tx_frame = 4'd0;
    logic [4:0] host_addr = 5'd0;
    logic [7:0] host_wdata = 8'd0;
    logic       tx_out, rx_new_flag, tx_mf_flag;
    logic [7:0] host_rdata;

    always #5 clk = ~clk;

    cas_sig_engine u_cas_sig_engine (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_bit_pos(rx_bit_pos),
        .rx_frame(rx_frame), .tx_in(tx_in), .tx_bit_pos(tx_bit_pos),
        .tx_frame(tx_frame), .tx_out(tx_out), .host_addr(host_addr),
        .host_we(host_we), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .rx_new_flag(rx_new_flag), .tx_mf_flag(tx_mf_flag)
    );

    int n_tests = 0, n_fail = 0;
    int mf_count = 0;
    int seed = 1;
    bit run = 0, done = 0;

    logic [7:0] m_txbuf [16];
    logic [7:0] m_shadow [16];
    logic       m_ins = 0, m_live = 0;

    typedef struct { logic exp; string req; } tx_item_t;
    tx_item_t exp_q [$];

    function automatic logic [7:0] rx_pat(int s, int f);
        if (s == 3) return (f % 2 == 1) ? 8'hFF : 8'h00;
        return 8'((s * 37 + f * 11 + 5) % 256);
    endfunction

    function automatic logic [7:0] tx_val(int f);
        if (f == 0) return 8'h0B;
        return 8'((f * 29 + 3) % 256);
    endfunction

    task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic hw_now(input logic [4:0] a, input logic [7:0] d);
        host_addr = a; host_wdata = d; host_we = 1'b1;
        @(posedge clk);
        if (a < 5'd16) m_txbuf[a[3:0]] = d;
        if (a == 5'd16) m_ins = d[0];
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic hw(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        hw_now(a, d);
    endtask

    task automatic hr(input logic [4:0] a, output logic [7:0] v);
        @(negedge clk);
        host_addr = a;
        @(posedge clk);
        #1 v = host_rdata;
    endtask

    // stream driver: position counters, serial data, expected tx bits
    initial begin
        int pos, frm, off;
        logic slot;
        tx_item_t it;
        pos = 0; frm = 8;
        for (int i = 0; i < 16; i++) begin m_txbuf[i] = 8'h00; m_shadow[i] = 8'h00; end
        wait (run);
        forever begin
            @(negedge clk);
            if (done) break;
            slot = (pos >= 128) && (pos <= 135);
            off  = pos - 128;
            rx_bit_pos = 8'(pos); tx_bit_pos = 8'(pos);
            rx_frame = 4'(frm);   tx_frame = 4'(frm);
            rx_bit = slot ? rx_pat(seed, frm)[7 - off] : (pos[0] ^ pos[4] ^ frm[1]);
            tx_in  = pos[0] ^ pos[3] ^ frm[0];
            if (pos == 0 && frm == 0) begin
                for (int i = 0; i < 16; i++) m_shadow[i] = m_txbuf[i];
                m_live = 1;
                mf_count++;
            end
            if (m_live && m_ins && slot) begin
                it.exp = m_shadow[frm][7 - off];
                it.req = (frm == 6) ? "R11" : "R10";
            end else begin
                it.exp = tx_in;
                it.req = "R9";
            end
            exp_q.push_back(it);
            pos++;
            if (pos == 256) begin pos = 0; frm = (frm + 1) % 16; end
        end
    end

    // monitor: compares tx_out one clock after the driven inputs
    always @(posedge clk) begin
        tx_item_t got_it;
        #2;
        if (exp_q.size() > 0 && !done) begin
            got_it = exp_q.pop_front();
            chk(got_it.req, {7'd0, tx_out}, {7'd0, got_it.exp});
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got hung run, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        chk("R1", {7'd0, tx_out}, 8'd0);
        chk("R1", {6'd0, tx_mf_flag, rx_new_flag}, 8'd0);
        rst_n = 1'b1;
        hr(5'd0, v);  chk("R1", v, 8'h00);
        hr(5'd15, v); chk("R1", v, 8'h00);
        hr(5'd16, v); chk("R1", v, 8'h00);
        hr(5'd17, v); chk("R1", v, 8'h00);

        run = 1;
        wait (mf_count == 1);
        repeat (5) @(negedge clk);
        chk("R4", {7'd0, rx_new_flag}, 8'd0);
        chk("R7", {7'd0, tx_mf_flag}, 8'd1);
        hr(5'd0, v); chk("R4", v, 8'h00);
        hw(5'd17, 8'h02);
        hr(5'd17, v); chk("R6", v, 8'h00);

        wait (mf_count == 2);
        seed = 2;
        repeat (5) @(negedge clk);
        chk("R5", {7'd0, rx_new_flag}, 8'd1);
        chk("R7", {7'd0, tx_mf_flag}, 8'd1);
        for (int f = 0; f < 16; f++) begin
            hr(5'(f), v); chk("R2", v, rx_pat(1, f));
        end
        repeat (20) @(negedge clk);
        chk("R5", {7'd0, rx_new_flag}, 8'd1);
        hw(5'd17, 8'h01);
        hr(5'd17, v); chk("R6", v, 8'h02);
        for (int f = 0; f < 16; f++) hw(5'(f), tx_val(f));
        wait (rx_frame == 4'd6);
        hr(5'd4, v); chk("R3", v, rx_pat(1, 4));
        hw(5'd16, 8'h03);
        hr(5'd2, v); chk("R8", v, tx_val(2));
        hr(5'd0, v); chk("R8", v, 8'h0B);
        hw(5'd16, 8'h01);
        hr(5'd2, v); chk("R8", v, rx_pat(1, 2));

        wait (mf_count == 3);
        hw_now(5'd6, 8'hA5);
        seed = 3;
        repeat (5) @(negedge clk);
        for (int f = 0; f < 4; f++) begin
            hr(5'(f), v); chk("R2", v, rx_pat(2, f));
        end

        wait (mf_count == 4);
        repeat (5) @(negedge clk);
        for (int f = 0; f < 16; f++) begin
            hr(5'(f), v); chk("R2", v, rx_pat(3, f));
        end
        hr(5'd6, v); chk("R8", v, rx_pat(3, 6));

        wait (mf_count == 5);
        hw(5'd16, 8'h00);
        repeat (600) @(negedge clk);
        done = 1;
        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule